// File: doc/BRIEF.md
# SDRAM Host Bus Adapter

This block connects a synchronous, SRAM-style host bus to an SDRAM command sequencer. The host presents a byte address, a chip select, separate read and write strobes, a two-bit transfer size and a mode-program strobe. The adapter captures the request in the cycle it is sampled. It raises one request line toward the sequencer: read, write or mode-program. It also presents the bank, row and column fields, four active-low byte-lane masks and write data placed on the correct lanes. The request stays up until the matching acknowledge arrives.

Back-pressure toward the host uses one active-low busy line. While busy is low, the host must hold address, data, size and strobes steady. Busy returns high one cycle after the acknowledge. Returned read data is then valid on the host data output and stays there until the next read completes. The host must release chip select before it can issue another request. The sequencer may take any number of cycles to acknowledge.

The parameter `RALIGN` selects the alignment of sub-word data. When it is 1, host data occupies the low-order bits. When it is 0, host data sits in its natural byte lanes.

Top module: `sdha_host_adapter`

## Requirements
- R1: After reset, host_busy_n is 1, host_rdata is 0, no request line is high, and seq_byte_mask_n is 4'b1111.
- R2: Busy low and request high appear one cycle after chip select low with a strobe low is sampled. They persist until the matching acknowledge is sampled. One cycle after that, busy is high and the request is low.
- R3: After a transfer completes, no new request starts while host_cs_n stays low. A request starts only after host_cs_n has been high for at least one cycle.
- R4: A write with host_mode_n low raises seq_mode_req instead of seq_wr_req. seq_mode_val equals host_wdata[10:0] and all masks are high. On a read, host_mode_n has no effect.
- R5: For a byte address A, seq_col = A[9:2], seq_row = A[20:10] and seq_bank = A[22:21].
- R6: Size code 1 is a byte on lane A[1:0], so only mask bit A[1:0] is low. Size code 2 is a half-word: masks 1:0 are low when A[1]=0, and masks 3:2 are low when A[1]=1. Size code 0 is a word, with all masks low.
- R7: Size code 3 behaves exactly as size code 0.
- R8: seq_wdata holds the host write data in the enabled lanes and zero elsewhere. With RALIGN=1, the host's low bytes are shifted up to the first enabled lane. With RALIGN=0, the bytes stay in their own lanes.
- R9: With RALIGN=1, read data from the enabled lanes is shifted down so the lowest enabled lane lands at bit 0. Upper bits are zero.
- R10: With RALIGN=0, read data keeps the enabled lanes in place and zeroes the others.
- R11: At most one request line is high at a time. Address, mask and data outputs stay stable while a request is pending.
- R12: If both strobes are low, the transfer is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 23 | Host byte address |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_size | input | 2 | Transfer size: 0 word, 1 byte, 2 half-word, 3 word |
| host_mode_n | input | 1 | Mode-program qualifier for writes, active low |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Aligned read data |
| host_busy_n | output | 1 | Stall to host, active low |
| seq_rd_req | output | 1 | Read request |
| seq_wr_req | output | 1 | Write request |
| seq_mode_req | output | 1 | Mode-program request |
| seq_rd_ack | input | 1 | Read acknowledge, read data valid |
| seq_wr_ack | input | 1 | Write acknowledge |
| seq_mode_ack | input | 1 | Mode-program acknowledge |
| seq_bank | output | 2 | Bank field |
| seq_row | output | 11 | Row field |
| seq_col | output | 8 | Column field |
| seq_mode_val | output | 11 | Mode register value |
| seq_byte_mask_n | output | 4 | Byte-lane masks, active low |
| seq_wdata | output | 32 | Lane-steered write data |
| seq_rdata | input | 32 | Read data from sequencer |

## Verification
The bench sweeps every size code against every low address pair, for both reads and writes. This separates the byte, half-word and word lane patterns, and confirms that code 3 copies code 0. Two instances share the inputs, one with each alignment setting, so the same read word shows shifted and unshifted results. Upper address bits alternate between two complementary patterns, which shows any cross-wiring of bank, row and column. Directed cases cover mode programming, a read with the mode strobe low, both strobes low, chip select held after completion, and acknowledge delays from zero to several cycles.

// File: rtl/sdha_pkg.sv
package sdha_pkg;
  typedef enum logic [1:0] {
    XK_READ  = 2'd0,
    XK_WRITE = 2'd1,
    XK_MODE  = 2'd2
  } xfer_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_HOLD = 2'd2
  } adapter_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_HALF = 2'd2;
endpackage

// File: rtl/sdha_lane_map.sv
module sdha_lane_map #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic [1:0]        size_code,
  input  logic [LANE_W-1:0] lane_addr,
  output logic [LANES-1:0]  lane_en,
  output logic [LANE_W-1:0] lane_base
);
  import sdha_pkg::*;

  int span;

  always_comb begin
    unique case (size_code)
      SZ_BYTE: span = 1;
      SZ_HALF: span = 2;
      default: span = LANES;
    endcase
    lane_base = lane_addr & ~LANE_W'(span - 1);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = (i >= int'(lane_base)) && (i < int'(lane_base) + span);
  end
endmodule

// File: rtl/sdha_wr_steer.sv
module sdha_wr_steer #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2,
  parameter bit RALIGN = 1'b1
) (
  input  logic [8*LANES-1:0] din,
  input  logic [LANES-1:0]   lane_en,
  input  logic [LANE_W-1:0]  lane_base,
  output logic [8*LANES-1:0] dout
);
  logic [8*LANES-1:0] placed;

  if (RALIGN) begin : g_shift
    assign placed = din << {lane_base, 3'b000};
  end else begin : g_keep
    assign placed = din;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[8*i +: 8] = lane_en[i] ? placed[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/sdha_rd_align.sv
module sdha_rd_align #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2,
  parameter bit RALIGN = 1'b1
) (
  input  logic [8*LANES-1:0] din,
  input  logic [LANES-1:0]   lane_en,
  input  logic [LANE_W-1:0]  lane_base,
  output logic [8*LANES-1:0] dout
);
  logic [8*LANES-1:0] kept;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign kept[8*i +: 8] = lane_en[i] ? din[8*i +: 8] : 8'h00;
  end

  if (RALIGN) begin : g_shift
    assign dout = kept >> {lane_base, 3'b000};
  end else begin : g_keep
    assign dout = kept;
  end
endmodule

// File: rtl/sdha_host_adapter.sv
module sdha_host_adapter #(
  parameter int DATA_W = 32,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 11,
  parameter int BANK_W = 2,
  parameter int MODE_W = 11,
  parameter bit RALIGN = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int ADDR_W = LANE_W + COL_W + ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [1:0]        host_size,
  input  logic              host_mode_n,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_busy_n,
  output logic              seq_rd_req,
  output logic              seq_wr_req,
  output logic              seq_mode_req,
  input  logic              seq_rd_ack,
  input  logic              seq_wr_ack,
  input  logic              seq_mode_ack,
  output logic [BANK_W-1:0] seq_bank,
  output logic [ROW_W-1:0]  seq_row,
  output logic [COL_W-1:0]  seq_col,
  output logic [MODE_W-1:0] seq_mode_val,
  output logic [LANES-1:0]  seq_byte_mask_n,
  output logic [DATA_W-1:0] seq_wdata,
  input  logic [DATA_W-1:0] seq_rdata
);
  import sdha_pkg::*;

  localparam int COL_LSB  = LANE_W;
  localparam int ROW_LSB  = COL_LSB + COL_W;
  localparam int BANK_LSB = ROW_LSB + ROW_W;

  adapter_state_t      state;
  xfer_kind_t          cap_kind;
  xfer_kind_t          new_kind;
  logic [ADDR_W-1:0]   cap_addr;
  logic [1:0]          cap_size;
  logic [DATA_W-1:0]   cap_wdata;
  logic                start;
  logic                ack_hit;
  logic [LANES-1:0]    lane_en;
  logic [LANE_W-1:0]   lane_base;
  logic [DATA_W-1:0]   rd_aligned;
  logic                data_req;

  assign start = (state == ST_IDLE) && !host_cs_n && (!host_rd_n || !host_wr_n);

  always_comb begin
    if (!host_wr_n) new_kind = host_mode_n ? XK_WRITE : XK_MODE;
    else            new_kind = XK_READ;
  end

  always_comb begin
    unique case (cap_kind)
      XK_READ:  ack_hit = seq_rd_ack;
      XK_WRITE: ack_hit = seq_wr_ack;
      XK_MODE:  ack_hit = seq_mode_ack;
      default:  ack_hit = 1'b0;
    endcase
  end

  sdha_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_map (
    .size_code (cap_size),
    .lane_addr (cap_addr[LANE_W-1:0]),
    .lane_en   (lane_en),
    .lane_base (lane_base)
  );

  sdha_wr_steer #(.LANES(LANES), .LANE_W(LANE_W), .RALIGN(RALIGN)) u_wr (
    .din       (cap_wdata),
    .lane_en   (lane_en),
    .lane_base (lane_base),
    .dout      (seq_wdata)
  );

  sdha_rd_align #(.LANES(LANES), .LANE_W(LANE_W), .RALIGN(RALIGN)) u_rd (
    .din       (seq_rdata),
    .lane_en   (lane_en),
    .lane_base (lane_base),
    .dout      (rd_aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cap_kind     <= XK_READ;
      cap_addr     <= '0;
      cap_size     <= '0;
      cap_wdata    <= '0;
      host_busy_n  <= 1'b1;
      host_rdata   <= '0;
      seq_rd_req   <= 1'b0;
      seq_wr_req   <= 1'b0;
      seq_mode_req <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state        <= ST_PEND;
            cap_kind     <= new_kind;
            cap_addr     <= host_addr;
            cap_size     <= host_size;
            cap_wdata    <= host_wdata;
            host_busy_n  <= 1'b0;
            seq_rd_req   <= (new_kind == XK_READ);
            seq_wr_req   <= (new_kind == XK_WRITE);
            seq_mode_req <= (new_kind == XK_MODE);
          end
        end
        ST_PEND: begin
          if (ack_hit) begin
            state        <= ST_HOLD;
            host_busy_n  <= 1'b1;
            seq_rd_req   <= 1'b0;
            seq_wr_req   <= 1'b0;
            seq_mode_req <= 1'b0;
            if (cap_kind == XK_READ) host_rdata <= rd_aligned;
          end
        end
        ST_HOLD: begin
          if (host_cs_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign data_req        = seq_rd_req || seq_wr_req;
  assign seq_byte_mask_n = data_req ? ~lane_en : '1;
  assign seq_col         = cap_addr[COL_LSB +: COL_W];
  assign seq_row         = cap_addr[ROW_LSB +: ROW_W];
  assign seq_bank        = cap_addr[BANK_LSB +: BANK_W];
  assign seq_mode_val    = cap_wdata[MODE_W-1:0];
endmodule

// File: rtl/sdha_checker.sv
module sdha_checker #(
  parameter int LANES  = 4,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cs_n,
  input logic              host_busy_n,
  input logic              seq_rd_req,
  input logic              seq_wr_req,
  input logic              seq_mode_req,
  input logic              seq_rd_ack,
  input logic              seq_wr_ack,
  input logic              seq_mode_ack,
  input logic [LANES-1:0]  seq_byte_mask_n,
  input logic [BANK_W-1:0] seq_bank,
  input logic [ROW_W-1:0]  seq_row,
  input logic [COL_W-1:0]  seq_col,
  input logic [DATA_W-1:0] seq_wdata
);
  logic any_req;
  logic done;
  assign any_req = seq_rd_req || seq_wr_req || seq_mode_req;
  assign done = (seq_rd_req && seq_rd_ack) || (seq_wr_req && seq_wr_ack) ||
                (seq_mode_req && seq_mode_ack);

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_rd_req, seq_wr_req, seq_mode_req})); // R11
  AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> !host_busy_n); // R2
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (host_busy_n && !any_req)); // R2
  AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_busy_n) |-> $past(!host_cs_n)); // R3
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && $past(any_req)) |-> ($stable(seq_byte_mask_n) && $stable(seq_row) &&
      $stable(seq_col) && $stable(seq_bank) && $stable(seq_wdata))); // R11
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wr_req |-> ($countones(~seq_byte_mask_n) == 1 || $countones(~seq_byte_mask_n) == 2 ||
      $countones(~seq_byte_mask_n) == LANES)); // R6
  AST_MODE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    seq_mode_req |-> (&seq_byte_mask_n)); // R4
endmodule

bind sdha_host_adapter sdha_checker #(
  .LANES(LANES), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_cs_n       (host_cs_n),
  .host_busy_n     (host_busy_n),
  .seq_rd_req      (seq_rd_req),
  .seq_wr_req      (seq_wr_req),
  .seq_mode_req    (seq_mode_req),
  .seq_rd_ack      (seq_rd_ack),
  .seq_wr_ack      (seq_wr_ack),
  .seq_mode_ack    (seq_mode_ack),
  .seq_byte_mask_n (seq_byte_mask_n),
  .seq_bank        (seq_bank),
  .seq_row         (seq_row),
  .seq_col         (seq_col),
  .seq_wdata       (seq_wdata)
);

// File: tb/sim_sdha_host_adapter.sv
module sim_sdha_host_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] host_addr = '0;
  logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_mode_n = 1'b1;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        seq_rd_ack = 1'b0, seq_wr_ack = 1'b0, seq_mode_ack = 1'b0;
  logic [31:0] seq_rdata = '0;

  logic [31:0] rdata0, rdata1, wdata0, wdata1;
  logic        busy0, busy1, rq0, wq0, mq0, rq1, wq1, mq1;
  logic [1:0]  bank0, bank1;
  logic [10:0] row0, row1, mval0, mval1;
  logic [7:0]  col0, col1;
  logic [3:0]  mask0, mask1;

  int ntot = 0;
  int nfail = 0;

  always #5 clk = ~clk; // 10 ns period, 100 MHz

  sdha_host_adapter #(.RALIGN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_cs_n(host_cs_n),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_size(host_size),
    .host_mode_n(host_mode_n), .host_wdata(host_wdata), .host_rdata(rdata0),
    .host_busy_n(busy0), .seq_rd_req(rq0), .seq_wr_req(wq0), .seq_mode_req(mq0),
    .seq_rd_ack(seq_rd_ack), .seq_wr_ack(seq_wr_ack), .seq_mode_ack(seq_mode_ack),
    .seq_bank(bank0), .seq_row(row0), .seq_col(col0), .seq_mode_val(mval0),
    .seq_byte_mask_n(mask0), .seq_wdata(wdata0), .seq_rdata(seq_rdata));

  sdha_host_adapter #(.RALIGN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_cs_n(host_cs_n),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_size(host_size),
    .host_mode_n(host_mode_n), .host_wdata(host_wdata), .host_rdata(rdata1),
    .host_busy_n(busy1), .seq_rd_req(rq1), .seq_wr_req(wq1), .seq_mode_req(mq1),
    .seq_rd_ack(seq_rd_ack), .seq_wr_ack(seq_wr_ack), .seq_mode_ack(seq_mode_ack),
    .seq_bank(bank1), .seq_row(row1), .seq_col(col1), .seq_mode_val(mval1),
    .seq_byte_mask_n(mask1), .seq_wdata(wdata1), .seq_rdata(seq_rdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 mode
  task automatic xfer(input bit do_wr, input bit do_rd, input bit mode_low,
                      input logic [22:0] a, input logic [1:0] sz, input logic [31:0] wd,
                      input logic [31:0] rd, input int dly, input bit hold_cs);
    int n, base, kind;
    logic [31:0] en, wmask, exp_w0, exp_w1, exp_r0, exp_r1;
    logic [3:0] exp_mask;
    n = (sz == 2'd1) ? 1 : (sz == 2'd2) ? 2 : 4;
    base = int'(a[1:0]) & ~(n - 1);
    en = '0;
    exp_mask = 4'hF;
    for (int i = 0; i < 4; i++)
      if (i >= base && i < base + n) begin
        en[8*i +: 8] = 8'hFF;
        exp_mask[i] = 1'b0;
      end
    wmask = (n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 32'd1);
    exp_w0 = (wd & wmask) << (8*base);
    exp_w1 = wd & en;
    exp_r0 = (rd & en) >> (8*base);
    exp_r1 = rd & en;
    kind = do_wr ? (mode_low ? 2 : 1) : 0;
    if (kind == 2) exp_mask = 4'hF;

    @(negedge clk);
    host_cs_n = 1'b0; host_rd_n = !do_rd; host_wr_n = !do_wr; host_mode_n = !mode_low;
    host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    check(busy0 == 1'b0 && busy1 == 1'b0, "R2 busy low after accept", {31'd0, busy0}, 32'd0);
    check({rq0, wq0, mq0} == {kind == 0, kind == 1, kind == 2} &&
          {rq1, wq1, mq1} == {rq0, wq0, mq0},
          (kind == 2) ? "R4 mode request" : (do_rd && do_wr) ? "R12 write wins" : "R2 request kind",
          {29'd0, rq0, wq0, mq0}, 32'(kind));
    check(col0 == a[9:2] && row0 == a[20:10] && bank0 == a[22:21], "R5 address split",
          {bank0, row0, col0, 11'd0}, {a[22:21], a[20:10], a[9:2], 11'd0});
    check(mask0 == exp_mask && mask1 == exp_mask,
          (sz == 2'd3) ? "R7 size 3 masks" : "R6 lane masks", {28'd0, mask0}, {28'd0, exp_mask});
    if (kind == 1) begin
      check(wdata0 == exp_w0, "R8 write steer aligned", wdata0, exp_w0);
      check(wdata1 == exp_w1, "R8 write steer natural", wdata1, exp_w1);
    end
    if (kind == 2) check(mval0 == wd[10:0], "R4 mode value", {21'd0, mval0}, {21'd0, wd[10:0]});
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check(busy0 == 1'b0 && (rq0 || wq0 || mq0), "R2 held until ack", {31'd0, busy0}, 32'd0);
    end
    seq_rd_ack = (kind == 0); seq_wr_ack = (kind == 1); seq_mode_ack = (kind == 2);
    seq_rdata = rd;
    @(negedge clk);
    seq_rd_ack = 1'b0; seq_wr_ack = 1'b0; seq_mode_ack = 1'b0;
    check(busy0 && busy1 && !(rq0 || wq0 || mq0), "R2 release after ack",
          {29'd0, rq0, wq0, mq0}, 32'd0);
    check(mask0 == 4'hF, "R1 masks idle high", {28'd0, mask0}, 32'hF);
    if (kind == 0) begin
      check(rdata0 == exp_r0, (mode_low ? "R4 read ignores mode" : "R9 read aligned"), rdata0, exp_r0);
      check(rdata1 == exp_r1, "R10 read natural", rdata1, exp_r1);
    end
    if (hold_cs) begin
      repeat (2) begin
        @(negedge clk);
        check(busy0 && !(rq0 || wq0 || mq0), "R3 no restart while cs held",
              {31'd0, busy0}, 32'd1);
      end
    end
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_mode_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nfail++; ntot++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy0 == 1'b1 && !(rq0 || wq0 || mq0) && mask0 == 4'hF && rdata0 == 32'd0,
          "R1 reset state", {27'd0, busy0, rq0, wq0, mq0, 1'b0}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy0 == 1'b1, "R1 idle after reset", {31'd0, busy0}, 32'd1);

    for (int hp = 0; hp < 2; hp++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 4; s++)
          for (int l = 0; l < 4; l++) begin
            logic [22:0] a;
            a = (hp == 0) ? 23'h55_5A5C : 23'h2A_A5A0;
            a[1:0] = 2'(l);
            xfer(w == 1, w == 0, 1'b0, a, 2'(s), 32'hA1B2_C3D4 + 32'(l * 16 + s),
                 32'h1122_3344 ^ 32'(hp * 32'h0F0F_0F0F), (l + s) % 4, 1'b0);
          end

    xfer(1'b1, 1'b0, 1'b1, 23'h12_3456, 2'd0, 32'hFFFF_F5A3, 32'd0, 2, 1'b0); // R4
    xfer(1'b0, 1'b1, 1'b1, 23'h00_0003, 2'd1, 32'd0, 32'hDEAD_BEEF, 1, 1'b0); // R4 read
    xfer(1'b1, 1'b1, 1'b0, 23'h7F_FFFE, 2'd2, 32'h0000_ABCD, 32'd0, 0, 1'b0); // R12
    xfer(1'b0, 1'b1, 1'b0, 23'h40_0001, 2'd1, 32'd0, 32'h8899_AABB, 3, 1'b1); // R3

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule